// File: doc/BRIEF.md
# Software-Loaded Translation Entry Array

This block holds a fully associative set of address translation entries that software fills, inspects and searches one command at a time. Each entry has two 32-bit words. The high word holds the effective page number, a page-size code and a valid flag. The low word holds the real page number and the execute and write grants. A command carries an opcode, an index operand and a data operand. Read and search commands return a 32-bit result one cycle later.

A process-ID register sits beside the array. A high-word write stamps the entry with the current register value. A high-word read copies that entry's stamp back into the register. A search only matches entries whose stamp equals the register. A search returns the index of the matching entry, or all ones when nothing matches. When the recording flag is set with a search, a 4-bit condition field is also updated from the search result and the summary-overflow input.

Top module: `sw_tlb_array`

## Requirements
- R1: After the asynchronous active-low reset:
  - every entry is invalid, with all its fields zero;
  - the process-ID register is 0, the condition field is 0 and no response is valid.
- R2: A high-word write (opcode 0) selects the entry given by the low log2(N_ENTRIES) bits of the index operand.
  - It takes the size code n from data bits 9:7 and the valid flag from bit 6.
  - It stores the page number from bits 31:10 with every address bit below 10+2n cleared.
  - Bit 5 and bits 4:0 have no effect.
- R3: A high-word write stamps the entry with the current process-ID register value.
- R4: A low-word write (opcode 1) stores the real page number from data bits 31:10, the execute grant from bit 9 and the write grant from bit 8. It leaves the entry's high-word fields unchanged.
- R5: A high-word read (opcode 2) returns this value: the page number in bits 31:10, ORed with the valid flag at bit 10 and the size code at bits 9:7. All other bits are 0.
- R6: A high-word read loads the entry's stamp into the process-ID register.
- R7: A low-word read (opcode 3) returns the real page number in bits 31:10, execute at bit 9, write at bit 8, and zeros below.
- R8: A search (opcode 4) looks up the effective address in the data operand. An entry matches when it is valid, its stamp equals the process-ID register, and the address equals its page number above bit 10+2n. The search returns the zero-extended index on a hit and 0xFFFFFFFF on a miss.
- R9: When several entries match, the lowest index is returned.
- R10: A search with record_i set loads the condition field with summary-overflow (so_i) at bit 0 and the hit flag at bit 1; bits 3:2 are 0. Any other command leaves the field unchanged.
- R11: A process-ID load (opcode 5) writes data bits PID_W-1:0 into the process-ID register. Only this command and the high-word read change that register.
- R12: rsp_valid_o is high in the cycle after a read or search command and low otherwise. Write and process-ID load commands give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Opcode (0..5) |
| idx_i | input | 32 | Index operand; low bits pick the entry |
| data_i | input | 32 | Write value, search address or process-ID value |
| record_i | input | 1 | Recording form of a search |
| so_i | input | 1 | Summary-overflow bit sampled by a recording search |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 32 | Read word or search result |
| cond_o | output | 4 | Condition field |
| pid_o | output | PID_W | Process-ID register |

## Verification
The bench writes entries with junk in the offset bits, the endian bit and the attribute bits. A design that masks the page number at a fixed granule, or that keeps the wrong bits, reads back a different high word.

Searches are run against entries that overlap:
- an entry with a matching address but a stale process ID must miss, or the ID comparison has been dropped;
- two hits at different sizes must return the lower index, or the priority encoder is reversed.

The process-ID register is checked after every command. This catches a high-word read that does not load the register, and a register that moves on other commands. The condition field is checked after non-recording searches, which must leave it held.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
  localparam int WORD_W   = 32;
  localparam int PAGE_LSB = 10;
  localparam int SZ_W     = 3;
  localparam int PN_W     = WORD_W - PAGE_LSB;

  typedef enum logic [2:0] {
    OP_WR_HI  = 3'd0,
    OP_WR_LO  = 3'd1,
    OP_RD_HI  = 3'd2,
    OP_RD_LO  = 3'd3,
    OP_SRCH   = 3'd4,
    OP_PID_LD = 3'd5
  } tlb_op_e;

  // page-number bit b maps to address bit b+PAGE_LSB; size code n keeps bits >= 2n
  function automatic logic [PN_W-1:0] pn_mask(input logic [SZ_W-1:0] sz);
    logic [PN_W-1:0] m;
    for (int b = 0; b < PN_W; b++) m[b] = (b >= 2 * int'(sz));
    return m;
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import sw_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int PID_W     = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_hi_i,
  input  logic                             wr_lo_i,
  input  logic [IDX_W-1:0]                 sel_i,
  input  logic [WORD_W-1:0]                data_i,
  input  logic [PID_W-1:0]                 pid_i,
  output logic [N_ENTRIES-1:0]             valid_o,
  output logic [N_ENTRIES-1:0][SZ_W-1:0]   size_o,
  output logic [N_ENTRIES-1:0][PN_W-1:0]   epn_o,
  output logic [N_ENTRIES-1:0][PN_W-1:0]   rpn_o,
  output logic [N_ENTRIES-1:0]             ex_o,
  output logic [N_ENTRIES-1:0]             wr_o,
  output logic [N_ENTRIES-1:0][PID_W-1:0]  tag_o
);
  logic [SZ_W-1:0] new_sz;
  assign new_sz = data_i[PAGE_LSB-1 -: SZ_W];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic hit_sel;
    assign hit_sel = (sel_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[e] <= 1'b0;
        size_o[e]  <= '0;
        epn_o[e]   <= '0;
        tag_o[e]   <= '0;
      end else if (wr_hi_i && hit_sel) begin
        valid_o[e] <= data_i[6];
        size_o[e]  <= new_sz;
        epn_o[e]   <= data_i[WORD_W-1:PAGE_LSB] & pn_mask(new_sz);
        tag_o[e]   <= pid_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rpn_o[e] <= '0;
        ex_o[e]  <= 1'b0;
        wr_o[e]  <= 1'b0;
      end else if (wr_lo_i && hit_sel) begin
        rpn_o[e] <= data_i[WORD_W-1:PAGE_LSB];
        ex_o[e]  <= data_i[9];
        wr_o[e]  <= data_i[8];
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import sw_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int PID_W     = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0]             valid_i,
  input  logic [N_ENTRIES-1:0][SZ_W-1:0]   size_i,
  input  logic [N_ENTRIES-1:0][PN_W-1:0]   epn_i,
  input  logic [N_ENTRIES-1:0][PID_W-1:0]  tag_i,
  input  logic [WORD_W-1:0]                addr_i,
  input  logic [PID_W-1:0]                 pid_i,
  output logic                             hit_o,
  output logic [IDX_W-1:0]                 idx_o
);
  logic [N_ENTRIES-1:0] hv;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign hv[e] = valid_i[e] && (tag_i[e] == pid_i) &&
                   ((addr_i[WORD_W-1:PAGE_LSB] & pn_mask(size_i[e])) == epn_i[e]);
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hv[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hv;
endmodule

// File: rtl/sw_tlb_array.sv
module sw_tlb_array
  import sw_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int PID_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [31:0]      idx_i,
  input  logic [31:0]      data_i,
  input  logic             record_i,
  input  logic             so_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_data_o,
  output logic [3:0]       cond_o,
  output logic [PID_W-1:0] pid_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);

  tlb_op_e op;
  assign op = tlb_op_e'(cmd_op_i);

  logic do_wr_hi, do_wr_lo, do_rd_hi, do_rd_lo, do_srch, do_pid;
  assign do_wr_hi = cmd_valid_i && (op == OP_WR_HI);
  assign do_wr_lo = cmd_valid_i && (op == OP_WR_LO);
  assign do_rd_hi = cmd_valid_i && (op == OP_RD_HI);
  assign do_rd_lo = cmd_valid_i && (op == OP_RD_LO);
  assign do_srch  = cmd_valid_i && (op == OP_SRCH);
  assign do_pid   = cmd_valid_i && (op == OP_PID_LD);

  logic [IDX_W-1:0] sel;
  assign sel = idx_i[IDX_W-1:0];

  logic [N_ENTRIES-1:0]             valid;
  logic [N_ENTRIES-1:0][SZ_W-1:0]   size;
  logic [N_ENTRIES-1:0][PN_W-1:0]   epn;
  logic [N_ENTRIES-1:0][PN_W-1:0]   rpn;
  logic [N_ENTRIES-1:0]             ex;
  logic [N_ENTRIES-1:0]             wr;
  logic [N_ENTRIES-1:0][PID_W-1:0]  tag;
  logic [PID_W-1:0]                 pid_q;

  tlb_entry_store #(.N_ENTRIES(N_ENTRIES), .PID_W(PID_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hi_i (do_wr_hi),
    .wr_lo_i (do_wr_lo),
    .sel_i   (sel),
    .data_i  (data_i),
    .pid_i   (pid_q),
    .valid_o (valid),
    .size_o  (size),
    .epn_o   (epn),
    .rpn_o   (rpn),
    .ex_o    (ex),
    .wr_o    (wr),
    .tag_o   (tag)
  );

  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  tlb_match #(.N_ENTRIES(N_ENTRIES), .PID_W(PID_W)) u_match (
    .valid_i (valid),
    .size_i  (size),
    .epn_i   (epn),
    .tag_i   (tag),
    .addr_i  (data_i),
    .pid_i   (pid_q),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  logic [WORD_W-1:0] hi_word, lo_word, srch_word, rsp_d;
  // valid overlays the lowest page-number bit
  assign hi_word   = {epn[sel], {PAGE_LSB{1'b0}}} |
                     {{(PN_W-1){1'b0}}, valid[sel], size[sel], 7'b0};
  assign lo_word   = {rpn[sel], ex[sel], wr[sel], 8'b0};
  assign srch_word = hit ? WORD_W'(hit_idx) : '1;

  always_comb begin
    rsp_d = '0;
    if (do_rd_hi)      rsp_d = hi_word;
    else if (do_rd_lo) rsp_d = lo_word;
    else if (do_srch)  rsp_d = srch_word;
  end

  logic             rsp_valid_q;
  logic [31:0]      rsp_data_q;
  logic [3:0]       cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      cond_q      <= '0;
      pid_q       <= '0;
    end else begin
      rsp_valid_q <= do_rd_hi || do_rd_lo || do_srch;
      if (do_rd_hi || do_rd_lo || do_srch) rsp_data_q <= rsp_d;
      if (do_srch && record_i)             cond_q     <= {2'b00, hit, so_i};
      if (do_pid)                          pid_q      <= data_i[PID_W-1:0];
      else if (do_rd_hi)                   pid_q      <= tag[sel];
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign cond_o      = cond_q;
  assign pid_o       = pid_q;
endmodule

// File: rtl/sw_tlb_array_chk.sv
module sw_tlb_array_chk #(
  parameter int N_ENTRIES = 64,
  parameter int PID_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [2:0]       cmd_op_i,
  input logic [31:0]      data_i,
  input logic             record_i,
  input logic             so_i,
  input logic             rsp_valid_o,
  input logic [31:0]      rsp_data_o,
  input logic [3:0]       cond_o,
  input logic [PID_W-1:0] pid_o
);
  logic is_rsp_cmd, is_srch, is_rec, is_pid_chg, is_pid_ld;
  assign is_rsp_cmd = cmd_valid_i && (cmd_op_i == 3'd2 || cmd_op_i == 3'd3 || cmd_op_i == 3'd4);
  assign is_srch    = cmd_valid_i && (cmd_op_i == 3'd4);
  assign is_rec     = is_srch && record_i;
  assign is_pid_ld  = cmd_valid_i && (cmd_op_i == 3'd5);
  assign is_pid_chg = is_pid_ld || (cmd_valid_i && cmd_op_i == 3'd2);

  p_rsp_follow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rsp_cmd |=> rsp_valid_o);
  p_rsp_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rsp_cmd |=> !rsp_valid_o);
  p_srch_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_srch |=> (rsp_data_o == 32'hFFFF_FFFF || rsp_data_o < 32'(N_ENTRIES)));
  p_cond_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rec |=> $stable(cond_o));
  p_cond_val_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rec |=> cond_o == {2'b00, rsp_data_o != 32'hFFFF_FFFF, $past(so_i)});
  p_pid_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_pid_chg |=> $stable(pid_o));
  p_pid_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pid_ld |=> pid_o == $past(data_i[PID_W-1:0]));
endmodule

bind sw_tlb_array sw_tlb_array_chk #(.N_ENTRIES(N_ENTRIES), .PID_W(PID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .data_i      (data_i),
  .record_i    (record_i),
  .so_i        (so_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .cond_o      (cond_o),
  .pid_o       (pid_o)
);

// File: tb/sim_sw_tlb_array.sv
module sim_sw_tlb_array;
  localparam int PID_W = 8;
  localparam int NV    = 23;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [31:0] idx_i = '0;
  logic [31:0] data_i = '0;
  logic record_i = 1'b0;
  logic so_i = 1'b0;
  logic rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic [3:0] cond_o;
  logic [PID_W-1:0] pid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sw_tlb_array #(.N_ENTRIES(64), .PID_W(PID_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .idx_i(idx_i), .data_i(data_i), .record_i(record_i), .so_i(so_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .cond_o(cond_o), .pid_o(pid_o)
  );

  // op idx data rec so chk exp cond pid
  localparam logic [89:0] VEC [NV] = '{
    {3'd5, 8'h00, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 8'h05},
    {3'd0, 8'h43, 32'h1234_5CF5, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 8'h05}, // R2 R3
    {3'd1, 8'h03, 32'hABCD_E7FF, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 8'h05}, // R4
    {3'd2, 8'h03, 32'h0,         1'b0, 1'b0, 1'b1, 32'h1234_5480, 4'h0, 8'h05},
    {3'd3, 8'h03, 32'h0,         1'b0, 1'b0, 1'b1, 32'hABCD_E700, 4'h0, 8'h05},
    {3'd4, 8'h00, 32'h1234_5ABC, 1'b1, 1'b0, 1'b1, 32'h3,         4'h2, 8'h05},
    {3'd4, 8'h00, 32'h1234_6000, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 4'h1, 8'h05},
    {3'd4, 8'h00, 32'h1234_5000, 1'b0, 1'b0, 1'b1, 32'h3,         4'h1, 8'h05},
    {3'd5, 8'h00, 32'h0000_0007, 1'b0, 1'b0, 1'b0, 32'h0,         4'h1, 8'h07},
    {3'd4, 8'h00, 32'h1234_5000, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'h0, 8'h07}, // R3 stale stamp
    {3'd0, 8'h01, 32'h1234_5440, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 8'h07},
    {3'd0, 8'h02, 32'h1234_F1C0, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 8'h07},
    {3'd4, 8'h00, 32'h1234_5400, 1'b1, 1'b0, 1'b1, 32'h1,         4'h2, 8'h07}, // R9
    {3'd4, 8'h00, 32'h1234_9999, 1'b1, 1'b1, 1'b1, 32'h2,         4'h3, 8'h07},
    {3'd2, 8'h03, 32'h0,         1'b0, 1'b0, 1'b1, 32'h1234_5480, 4'h3, 8'h05}, // R6
    {3'd4, 8'h00, 32'h1234_5000, 1'b0, 1'b0, 1'b1, 32'h3,         4'h3, 8'h05},
    {3'd0, 8'h03, 32'h1234_5000, 1'b0, 1'b0, 1'b0, 32'h0,         4'h3, 8'h05},
    {3'd4, 8'h00, 32'h1234_5000, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'h0, 8'h05},
    {3'd2, 8'h03, 32'h0,         1'b0, 1'b0, 1'b1, 32'h1234_5000, 4'h0, 8'h05},
    {3'd3, 8'h03, 32'h0,         1'b0, 1'b0, 1'b1, 32'hABCD_E700, 4'h0, 8'h05}, // R4 low kept
    {3'd1, 8'h02, 32'h0000_0200, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 8'h05},
    {3'd3, 8'h02, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0000_0200, 4'h0, 8'h05},
    {3'd2, 8'h02, 32'h0,         1'b0, 1'b0, 1'b1, 32'h1234_0580, 4'h0, 8'h07}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string data_req(input logic [2:0] op);
    case (op)
      3'd2:    return "R5";
      3'd3:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // drive at negedge; result sampled at the next negedge
  task automatic do_cmd(input logic [2:0] op, input logic [31:0] idx, input logic [31:0] dat,
                        input logic rec, input logic so);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; idx_i = idx; data_i = dat; record_i = rec; so_i = so;
    @(negedge clk);
    cmd_valid_i = 1'b0; record_i = 1'b0; so_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {31'b0, rsp_valid_o}, 32'h0);
    check("R1", {28'b0, cond_o}, 32'h0);
    check("R1", {24'b0, pid_o}, 32'h0);
    rst_ni = 1'b1;
    do_cmd(3'd4, 0, 32'h0, 1'b0, 1'b0);
    check("R1", rsp_data_o, 32'hFFFF_FFFF);
    do_cmd(3'd2, 0, 32'h0, 1'b0, 1'b0);
    check("R1", rsp_data_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][89:87];
      do_cmd(op, {24'b0, VEC[i][86:79]}, VEC[i][78:47], VEC[i][46], VEC[i][45]);
      check("R12", {31'b0, rsp_valid_o}, {31'b0, (op == 3'd2 || op == 3'd3 || op == 3'd4)});
      if (VEC[i][44]) check(data_req(op), rsp_data_o, VEC[i][43:12]);
      check("R10", {28'b0, cond_o}, {28'b0, VEC[i][11:8]});
      check("R11", {24'b0, pid_o}, {24'b0, VEC[i][7:0]});
    end

    // R2 largest size code at the top index, stamped with PID 7
    do_cmd(3'd0, 32'h0000_003F, 32'hABFF_FFC0, 1'b0, 1'b0);
    check("R12", {31'b0, rsp_valid_o}, 32'h0);
    do_cmd(3'd2, 32'h0000_003F, 32'h0, 1'b0, 1'b0);
    check("R2", rsp_data_o, 32'hAB00_0780);
    do_cmd(3'd4, 0, 32'hABCD_EF01, 1'b1, 1'b1);
    check("R8", rsp_data_o, 32'h0000_003F);
    check("R10", {28'b0, cond_o}, 32'h3);
    do_cmd(3'd4, 0, 32'hAC00_0000, 1'b1, 1'b0);
    check("R8", rsp_data_o, 32'hFFFF_FFFF);
    check("R10", {28'b0, cond_o}, 32'h0);

    // R1 mid-run reset clears contents
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1", {24'b0, pid_o}, 32'h0);
    rst_ni = 1'b1;
    do_cmd(3'd2, 32'h0000_003F, 32'h0, 1'b0, 1'b0);
    check("R1", rsp_data_o, 32'h0);
    do_cmd(3'd4, 0, 32'h0000_0000, 1'b0, 1'b0);
    check("R1", rsp_data_o, 32'hFFFF_FFFF);

    finish_run();
  end
endmodule